// File: doc/BRIEF.md
# Low-Power Timer Core with Deferred Period Update

This block is a 16-bit up-counter with three programmable values: a period limit, a compare value and a repetition count. Software sets these through a write-only register bus. Each period, the counter runs from zero up to the period limit and then wraps back to zero. It advances on one of two sources: an internal tick, which is the core clock divided by a power of two, or a selected edge of an external input. The external input first passes through a two-flop synchronizer.

A configuration bit controls when new period, compare and repetition values take effect:
- **Direct update:** a bus write changes the active value at once.
- **Deferred update:** the written value waits in a shadow register. It moves to the active register at an update event. An update event is a wrap that ends a run of (repetition + 1) periods.

Three sticky flags record compare hits, wraps and valid external edges. Each flag is ANDed with its own enable, and the results are ORed onto one interrupt line.

The sequencing is held in a two-state machine:
- **ST_OFF:** the counter, prescaler and repetition count are held at zero. Pending shadow values are copied straight into the active registers.
- **ST_RUN:** counting is live.

There are two transitions. `go` (ST_OFF to ST_RUN) is taken on the clock after the enable bit is seen set. `halt` (ST_RUN to ST_OFF) is taken on the clock after the enable bit is seen clear.

Top module: `lp_timer`

## Requirements
- R1: After reset: `count_o` = 0, `flags_o` = 0 and `irq_o` = 0. The reset register state is:
  - configuration all zero: direct update, internal source, rising edge, prescaler exponent 0;
  - period limit 0xFFFF;
  - compare value 0, repetition 0, interrupt enables 0.
- R2: In internal mode, the counter advances once every 2^p core clocks while running. The exponent p is in bits 5:3 of the configuration register (address 1). The first advance happens 2^p clocks after the machine enters ST_RUN. ST_RUN is entered one clock after bit 0 of the control register (address 0) is written as 1.
- R3: A tick taken while the count equals the active period limit (written at address 4) returns the count to 0. It also sets flag bit 1.
- R4: A tick taken while the count equals the active compare value (written at address 5) sets flag bit 0.
- R5: With configuration bit 0 (deferred update) clear, a write to the period, compare or repetition register changes the active value on the same clock edge.
- R6: With configuration bit 0 set while running, written values are held in the shadow registers. They become active only at an update event: a wrap taken after the repetition register (address 6) has already counted that many earlier wraps.
- R7: With configuration bit 1 set, only valid external edges advance the counter. A valid edge is rising, or falling when configuration bit 2 is set. An edge takes effect two clocks after it is captured by the first synchronizer flop. Internal ticks have no effect in this mode.
- R8: Every valid external edge seen while running sets flag bit 2, whatever the count source.
- R9: Flags are sticky. A flag clears only when a 1 is written to its bit at address 3; if a set and a clear arrive together, the set wins. `irq_o` is the OR over all flags of (flag AND its enable bit from address 2).
- R10: Writes to the interrupt-enable register (address 2) are ignored while the enable bit is set or the machine is still in ST_RUN.
- R11: In ST_OFF the count stays at 0, and any value pending in a shadow register is copied into its active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| ext_i | input | 1 | Asynchronous external count/trigger input |
| count_o | output | 16 | Current counter value |
| flags_o | output | 3 | Sticky flags: bit 0 compare, bit 1 wrap, bit 2 external edge |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The embedded properties check the following on every cycle:
- the count holds steady between ticks;
- a wrap always lands on zero;
- the count is zero once the machine has settled in ST_OFF;
- active values stay frozen in deferred mode until an update event;
- the interrupt-enable register stays locked while running;
- flags drop only when a clear is written.

Some behaviour depends on multi-cycle sequences, and only the bench scenarios can show it:
- a deferred write that survives an intermediate wrap under a nonzero repetition count;
- a pending shadow value that appears after a stop and restart;
- the exact clock latency of a synchronized external edge under either polarity;
- the prescaled tick spacing.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int FLAG_N  = 3;
    localparam int FLG_CMP = 0;
    localparam int FLG_WRP = 1;
    localparam int FLG_EXT = 2;
    localparam int PSEL_W  = 3;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd1;
    localparam logic [2:0] A_IEN  = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_VAL0 = 3'd4;

    localparam int VAL_N = 3;

    typedef enum logic {ST_OFF, ST_RUN} run_st_e;
endpackage

// File: rtl/lpt_tick_gen.sv
module lpt_tick_gen #(
    parameter int PSEL_W = lpt_pkg::PSEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              ext_mode_i,
    input  logic              ext_fall_i,
    input  logic [PSEL_W-1:0] presc_i,
    input  logic              ext_i,
    output logic              tick_o,
    output logic              ext_edge_o
);
    localparam int PC_W = (1 << PSEL_W) - 1;

    logic [2:0]      sync_q;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask;
    logic            edge_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pc_q <= '0;
        end else if (!run_i) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    always_comb begin
        mask     = (PC_W'(1) << presc_i) - PC_W'(1);
        edge_hit = ext_fall_i ? (sync_q[2] & ~sync_q[1]) : (sync_q[1] & ~sync_q[2]);
        ext_edge_o = run_i & edge_hit;
        tick_o     = run_i & (ext_mode_i ? edge_hit : ((pc_q & mask) == mask));
    end
endmodule

// File: rtl/lpt_core.sv
module lpt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] rep_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             cmp_hit_o,
    output logic             arr_hit_o,
    output logic             upd_o
);
    import lpt_pkg::*;

    run_st_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rep_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en_i)  state_d = ST_RUN;   // go
            ST_RUN: if (!en_i) state_d = ST_OFF;   // halt
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        run_o     = (state_q == ST_RUN);
        arr_hit_o = run_o && tick_i && (cnt_q == arr_i);
        cmp_hit_o = run_o && tick_i && (cnt_q == cmp_i);
        upd_o     = arr_hit_o && (rep_q >= rep_i);
        cnt_o     = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            rep_q <= '0;
        end else if (!run_o) begin
            cnt_q <= '0;
            rep_q <= '0;
        end else if (tick_i) begin
            cnt_q <= arr_hit_o ? '0 : cnt_q + CNT_W'(1);
            if (arr_hit_o) begin
                rep_q <= upd_o ? '0 : rep_q + CNT_W'(1);
            end
        end
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && !tick_i) |=> $stable(cnt_q));
    // R3
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_hit_o |=> (cnt_q == '0));
    // R11
    off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OFF && $past(state_q) == ST_OFF) |-> (cnt_q == '0));
endmodule

// File: rtl/lpt_regfile.sv
module lpt_regfile #(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = lpt_pkg::PSEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    input  logic              run_i,
    input  logic              upd_i,
    output logic              en_o,
    output logic              ext_mode_o,
    output logic              ext_fall_o,
    output logic [PSEL_W-1:0] presc_o,
    output logic [lpt_pkg::FLAG_N-1:0] ien_o,
    output logic [lpt_pkg::FLAG_N-1:0] clr_o,
    output logic [CNT_W-1:0]  arr_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  rep_o
);
    import lpt_pkg::*;

    logic              en_q, preload_q, ext_mode_q, ext_fall_q;
    logic [PSEL_W-1:0] presc_q;
    logic [FLAG_N-1:0] ien_q;
    logic [CNT_W-1:0]  sh_q  [VAL_N];
    logic [CNT_W-1:0]  act_q [VAL_N];
    logic              direct;

    assign direct = !preload_q || !run_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q       <= 1'b0;
            preload_q  <= 1'b0;
            ext_mode_q <= 1'b0;
            ext_fall_q <= 1'b0;
            presc_q    <= '0;
            ien_q      <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == A_CTRL) en_q <= bus_wdata_i[0];
            if (bus_addr_i == A_CFG)
                {presc_q, ext_fall_q, ext_mode_q, preload_q} <= bus_wdata_i[PSEL_W+2:0];
            if (bus_addr_i == A_IEN && !en_q && !run_i) ien_q <= bus_wdata_i[FLAG_N-1:0];
        end
    end

    for (genvar g = 0; g < VAL_N; g++) begin : g_val
        localparam logic [CNT_W-1:0] RST_V = (g == 0) ? {CNT_W{1'b1}} : '0;
        logic wr;
        assign wr = bus_we_i && (bus_addr_i == A_VAL0 + 3'(g));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                sh_q[g]  <= RST_V;
                act_q[g] <= RST_V;
            end else begin
                if (wr) sh_q[g] <= bus_wdata_i;
                if (wr && direct) act_q[g] <= bus_wdata_i;
                else if (!run_i || upd_i) act_q[g] <= sh_q[g];
            end
        end

        // R6
        defer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_i && preload_q && !upd_i) |=> $stable(act_q[g]));
    end

    assign en_o       = en_q;
    assign ext_mode_o = ext_mode_q;
    assign ext_fall_o = ext_fall_q;
    assign presc_o    = presc_q;
    assign ien_o      = ien_q;
    assign clr_o      = (bus_we_i && bus_addr_i == A_CLR) ? bus_wdata_i[FLAG_N-1:0] : '0;
    assign arr_o      = act_q[0];
    assign cmp_o      = act_q[1];
    assign rep_o      = act_q[2];

    // R10
    ien_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> $stable(ien_q));
endmodule

// File: rtl/lpt_flags.sv
module lpt_flags #(
    parameter int FLAG_N = lpt_pkg::FLAG_N
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_N-1:0] set_i,
    input  logic [FLAG_N-1:0] clr_i,
    input  logic [FLAG_N-1:0] ien_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              irq_o
);
    logic [FLAG_N-1:0] flags_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & ien_i);

    // R9
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/lp_timer.sv
module lp_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_we_i,
    input  logic [2:0]       bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    input  logic             ext_i,
    output logic [CNT_W-1:0] count_o,
    output logic [2:0]       flags_o,
    output logic             irq_o
);
    import lpt_pkg::*;

    logic              en, ext_mode, ext_fall, run, tick, ext_edge;
    logic              cmp_hit, arr_hit, upd;
    logic [PSEL_W-1:0] presc;
    logic [FLAG_N-1:0] ien, clr, set;
    logic [CNT_W-1:0]  arr, cmp, rep;

    lpt_regfile #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .run_i(run), .upd_i(upd),
        .en_o(en), .ext_mode_o(ext_mode), .ext_fall_o(ext_fall), .presc_o(presc),
        .ien_o(ien), .clr_o(clr), .arr_o(arr), .cmp_o(cmp), .rep_o(rep)
    );

    lpt_tick_gen #(.PSEL_W(PSEL_W)) u_tick (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
        .ext_mode_i(ext_mode), .ext_fall_i(ext_fall), .presc_i(presc),
        .ext_i(ext_i), .tick_o(tick), .ext_edge_o(ext_edge)
    );

    lpt_core #(.CNT_W(CNT_W)) u_core (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .tick_i(tick),
        .arr_i(arr), .cmp_i(cmp), .rep_i(rep),
        .cnt_o(count_o), .run_o(run),
        .cmp_hit_o(cmp_hit), .arr_hit_o(arr_hit), .upd_o(upd)
    );

    always_comb begin
        set          = '0;
        set[FLG_CMP] = cmp_hit;
        set[FLG_WRP] = arr_hit;
        set[FLG_EXT] = ext_edge;
    end

    lpt_flags #(.FLAG_N(FLAG_N)) u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(clr),
        .ien_i(ien), .flags_o(flags_o), .irq_o(irq_o)
    );
endmodule

// File: tb/test_lp_timer.sv
module test_lp_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYC     = 20000;
    localparam int NV         = 6;
    localparam int V_ARR [NV] = '{9, 9, 4, 0, 3, 100};
    localparam int V_CMP [NV] = '{5, 3, 2, 0, 7, 50};
    localparam int V_N   [NV] = '{5, 5, 8, 4, 10, 40};
    localparam int V_CNT [NV] = '{4, 4, 2, 0, 1, 39};
    localparam int V_FLG [NV] = '{0, 1, 3, 3, 2, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        ext = 1'b0;
    logic [15:0] count;
    logic [2:0]  flags;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_timer i_lp_timer (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .ext_i(ext), .count_o(count), .flags_o(flags), .irq_o(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop();
        wr(3'd0, 0);
        step(2);
    endtask

    task automatic pulse();
        ext = 1'b1; step(3);
        ext = 1'b0; step(3);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        // R1/R2 default config: internal source, exponent 0
        wr(3'd0, 1); step(5);
        chk("R2 default tick count", count, 4);
        stop();

        // table walk: R3, R4, R9
        for (int i = 0; i < NV; i++) begin
            stop();
            wr(3'd3, 7); wr(3'd2, 3);
            wr(3'd4, V_ARR[i]); wr(3'd5, V_CMP[i]);
            wr(3'd0, 1); step(V_N[i]);
            chk($sformatf("R3 vec%0d count", i), count, V_CNT[i]);
            chk($sformatf("R4 vec%0d flags", i), flags, V_FLG[i]);
            chk($sformatf("R9 vec%0d irq", i), irq, int'((V_FLG[i] & 3) != 0));
        end

        // R10 enable lock, R9 sticky and clear
        stop(); wr(3'd3, 7); wr(3'd2, 0);
        wr(3'd4, 3); wr(3'd5, 1); wr(3'd0, 1);
        wr(3'd2, 7); step(8);
        chk("R10 irq masked", irq, 0);
        stop();
        chk("R9 flags sticky", flags, 3);
        chk("R10 ier unchanged", irq, 0);
        wr(3'd2, 7);
        chk("R9 irq enabled", irq, 1);
        wr(3'd3, 1);
        chk("R9 clear cmp", flags, 2);
        wr(3'd3, 2);
        chk("R9 clear wrap", flags, 0);
        chk("R9 irq low", irq, 0);

        // R5 direct update
        wr(3'd1, 0); wr(3'd4, 20); wr(3'd5, 200); wr(3'd0, 1);
        step(6); chk("R5 count before write", count, 5);
        wr(3'd4, 8); step(2);
        chk("R5 count at new limit", count, 8);
        chk("R5 no wrap yet", flags, 0);
        step(1);
        chk("R5 wrap at new limit", count, 0);
        chk("R5 wrap flag", flags, 2);

        // R6 deferred update
        stop(); wr(3'd3, 7); wr(3'd1, 1); wr(3'd4, 20); wr(3'd0, 1);
        step(6); wr(3'd4, 8); step(3);
        chk("R6 old limit kept", count, 9);
        chk("R6 no wrap", flags, 0);
        step(11); chk("R6 reach old limit", count, 20);
        step(1); chk("R6 wrap old limit", count, 0);
        step(8); chk("R6 new limit count", count, 8);
        step(1); chk("R6 wrap new limit", count, 0);

        // R11 pending shadow loaded when stopped
        wr(3'd4, 2); stop();
        chk("R11 count held zero", count, 0);
        wr(3'd0, 1); step(5);
        chk("R11 pending limit active", count, 1);

        // R6 repetition
        stop(); wr(3'd6, 1); wr(3'd4, 3); wr(3'd0, 1);
        step(1); wr(3'd4, 5); step(6);
        chk("R6 rep first period", count, 3);
        step(1); chk("R6 rep second wrap", count, 0);
        step(4); chk("R6 rep update applied", count, 4);
        stop(); wr(3'd6, 0);

        // R2 prescaler exponent 2
        wr(3'd1, 2 << 3); wr(3'd4, 1000); wr(3'd0, 1);
        step(8); chk("R2 prescaled one tick", count, 1);
        step(1); chk("R2 prescaled two ticks", count, 2);

        // R7/R8 external rising
        stop(); wr(3'd3, 7); wr(3'd1, 2); wr(3'd4, 100); wr(3'd0, 1);
        step(10);
        chk("R7 internal ignored", count, 0);
        chk("R8 no edge flag", flags, 0);
        for (int k = 0; k < 5; k++) pulse();
        chk("R7 rising edges counted", count, 5);
        chk("R8 edge flag", flags, 4);

        // R7 falling polarity
        stop(); wr(3'd3, 7); wr(3'd1, 6); wr(3'd0, 1); step(3);
        ext = 1'b1; step(3);
        chk("R7 rising ignored", count, 0);
        ext = 1'b0; step(3);
        chk("R7 falling counted", count, 1);
        pulse(); pulse();
        chk("R7 falling total", count, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule